// File: doc/BRIEF.md
# Multiword DMA Strobe Timing Generator

This block is the master side of a 16-bit multiword DMA link. The link has four control lines: a request input from the peripheral, an acknowledge output, a read strobe and a write strobe. A client starts a burst by giving a timing mode (0, 1 or 2), a direction and a word count. The block then waits for the request line and raises acknowledge. It runs one strobe pulse per word, and it releases acknowledge when the burst completes or when the peripheral withdraws its request.

All timing is counted in system clock cycles. Each nanosecond limit is divided by the `CLK_PERIOD_NS` parameter and rounded up. The active phase of each word takes the largest of three minimums: the strobe width, the read data-valid delay plus one cycle, and the write data setup. The recovery phase takes the largest of the recovery, hold and acknowledge-hold minimums. It is also stretched until the active phase plus the recovery phase reaches the per-mode minimum cycle time. Read data is sampled in the last active cycle. Write data is loaded from the client as the strobe starts and is held through recovery. Each of the request, acknowledge and strobe pins has its own polarity select.

Top module: `mdma_strobe_gen`

## Requirements
- R1: During reset, `busy` and `bus_oe` are 0, `rd_valid` is 0, and the acknowledge and both strobe pins sit at their inactive levels.
- R2: Each strobe stays active for exactly A(m) cycles. With P = `CLK_PERIOD_NS` and c(x) = ceil(x/P), A(m) = max(c(width), c(data delay)+1, c(write setup)). The nanosecond limits for modes 0/1/2 are: width 215/80/70, data delay 150/60/50, write setup 100/30/20.
- R3: Within a burst, while the request stays asserted, the strobe is inactive for exactly R(m) cycles between words. R(m) = max(c(recovery), c(write hold), c(ack hold), c(cycle) − A(m)). The nanosecond limits for modes 0/1/2 are: recovery 215/50/25, write hold 20/15/10, ack hold 20/5/5, cycle 480/150/120.
- R4: The acknowledge pin becomes active exactly one cycle before the first strobe of every run of words. It stays active through every recovery phase, including R(m) cycles after the last strobe of the burst. No strobe is ever active without acknowledge.
- R5: A strobe starts only while the request is asserted. If the request is not asserted when a recovery phase ends and words remain, acknowledge drops. The burst resumes with a fresh one-cycle setup when the request returns, and every requested word is still moved.
- R6: On reads, `bus_in` is captured in the last active cycle of the read strobe. `rd_valid` pulses for one cycle, in the first cycle after the strobe is released, with the captured word on `rd_word`. There is one pulse per word and none on writes.
- R7: On writes, `wr_pop` is high in the cycle just before each write strobe goes active, and the block takes `wr_word` at that edge. The word stays on `bus_out` through the active phase and the recovery phase that follow. `bus_oe` is high exactly while acknowledge is active in a write burst.
- R8: Polarity inputs: `pol_dreq_high`, `pol_dack_high` and `pol_strobe_high` are 1 for an active-high pin and 0 for an active-low pin. The strobe select covers both strobes. The strobe not used by the current direction is never driven active.
- R9: A mode select of 3 gives the same timing as mode 2.
- R10: A `start` with `word_count` of 0 is ignored: `busy` stays 0 and acknowledge stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Timing mode, latched at start |
| dir_write | input | 1 | 1 = write burst, 0 = read burst, latched at start |
| start | input | 1 | Begin a burst (ignored while busy) |
| word_count | input | COUNT_W | Number of words in the burst |
| pol_dreq_high | input | 1 | Request pin polarity, 1 = active high |
| pol_dack_high | input | 1 | Acknowledge pin polarity, 1 = active high |
| pol_strobe_high | input | 1 | Strobe pin polarity, 1 = active high |
| dreq_pin | input | 1 | Request from the peripheral |
| dack_pin | output | 1 | Acknowledge to the peripheral |
| dior_pin | output | 1 | Read strobe |
| diow_pin | output | 1 | Write strobe |
| bus_in | input | DATA_W | Data bus input, read bursts |
| bus_out | output | DATA_W | Data bus output, write bursts |
| bus_oe | output | 1 | Output enable for `bus_out` |
| wr_word | input | DATA_W | Next word to write, supplied by the client |
| wr_pop | output | 1 | Client word taken at the next edge |
| rd_word | output | DATA_W | Last word read |
| rd_valid | output | 1 | One-cycle pulse, `rd_word` is new |
| busy | output | 1 | Burst in progress |

## Verification
Pins are decoded from the current and previous negative-edge samples, so each edge lands on a known cycle. A strobe pulse is A(m) samples long, the gap between pulses is R(m) samples of acknowledge-only, and a fresh run starts with one acknowledge-only sample. `rd_valid` and `wr_pop` are each due one cycle away from a strobe edge: the first sample after a read strobe falls, and the sample before a write strobe rises. The read data the bench drives becomes valid only once the data-delay count has passed, so a capture taken too early returns a junk value. A sweep covers every mode, both directions, all four polarity combinations and both a one-word and a three-word burst, with a request dropout run in each direction.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SETUP,
    ST_ACT,
    ST_REC
  } mdma_state_e;

  localparam int NUM_MODES = 3;

  // Limit selectors for mode_ns()
  localparam int LIM_CYCLE    = 0;
  localparam int LIM_WIDTH    = 1;
  localparam int LIM_RECOVER  = 2;
  localparam int LIM_RD_DELAY = 3;
  localparam int LIM_WR_SETUP = 4;
  localparam int LIM_WR_HOLD  = 5;
  localparam int LIM_ACK_HOLD = 6;

  function automatic int clamp_mode(input int m);
    return (m >= NUM_MODES) ? NUM_MODES - 1 : m;
  endfunction

  // Nanosecond limit for a mode and limit selector
  function automatic int mode_ns(input int m, input int sel);
    int mm;
    mm = clamp_mode(m);
    case (sel)
      LIM_CYCLE:    return (mm == 0) ? 480 : (mm == 1) ? 150 : 120;
      LIM_WIDTH:    return (mm == 0) ? 215 : (mm == 1) ? 80  : 70;
      LIM_RECOVER:  return (mm == 0) ? 215 : (mm == 1) ? 50  : 25;
      LIM_RD_DELAY: return (mm == 0) ? 150 : (mm == 1) ? 60  : 50;
      LIM_WR_SETUP: return (mm == 0) ? 100 : (mm == 1) ? 30  : 20;
      LIM_WR_HOLD:  return (mm == 0) ? 20  : (mm == 1) ? 15  : 10;
      default:      return (mm == 0) ? 20  : 5;
    endcase
  endfunction

  function automatic int ns_to_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Active phase length in clocks
  function automatic int act_cycles(input int m, input int period);
    int w;
    w = ns_to_cycles(mode_ns(m, LIM_WIDTH), period);
    w = imax(w, ns_to_cycles(mode_ns(m, LIM_RD_DELAY), period) + 1);
    w = imax(w, ns_to_cycles(mode_ns(m, LIM_WR_SETUP), period));
    return w;
  endfunction

  // Recovery phase length in clocks, stretched to meet the cycle minimum
  function automatic int rec_cycles(input int m, input int period);
    int r;
    r = ns_to_cycles(mode_ns(m, LIM_RECOVER), period);
    r = imax(r, ns_to_cycles(mode_ns(m, LIM_WR_HOLD), period));
    r = imax(r, ns_to_cycles(mode_ns(m, LIM_ACK_HOLD), period));
    r = imax(r, ns_to_cycles(mode_ns(m, LIM_CYCLE), period) - act_cycles(m, period));
    return r;
  endfunction

endpackage

// File: rtl/mdma_timing_table.sv
module mdma_timing_table
  import mdma_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int TIMER_W       = 8
) (
  input  logic [1:0]         mode,
  output logic [TIMER_W-1:0] act_len,
  output logic [TIMER_W-1:0] rec_len
);

  logic [TIMER_W-1:0] act_tbl [NUM_MODES];
  logic [TIMER_W-1:0] rec_tbl [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    assign act_tbl[m] = TIMER_W'(act_cycles(m, CLK_PERIOD_NS));
    assign rec_tbl[m] = TIMER_W'(rec_cycles(m, CLK_PERIOD_NS));
  end

  always_comb begin
    act_len = act_tbl[NUM_MODES-1];
    rec_len = rec_tbl[NUM_MODES-1];
    for (int m = 0; m < NUM_MODES; m++) begin
      if (int'(mode) == m) begin
        act_len = act_tbl[m];
        rec_len = rec_tbl[m];
      end
    end
  end

endmodule

// File: rtl/mdma_phase_counter.sv
module mdma_phase_counter #(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  output logic               done
);

  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - TIMER_W'(1);
  end

  // High in the final cycle of a loaded phase
  assign done = (cnt_q == TIMER_W'(1));

endmodule

// File: rtl/mdma_pin_polarity.sv
module mdma_pin_polarity #(
  parameter int N = 1
) (
  input  logic [N-1:0] level_in,
  input  logic [N-1:0] active_high,
  output logic [N-1:0] level_out
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign level_out[i] = active_high[i] ? level_in[i] : ~level_in[i];
  end

endmodule

// File: rtl/mdma_strobe_gen.sv
module mdma_strobe_gen
  import mdma_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int DATA_W        = 16,
  parameter int COUNT_W       = 16,
  parameter int TIMER_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               dir_write,
  input  logic               start,
  input  logic [COUNT_W-1:0] word_count,
  input  logic               pol_dreq_high,
  input  logic               pol_dack_high,
  input  logic               pol_strobe_high,
  input  logic               dreq_pin,
  output logic               dack_pin,
  output logic               dior_pin,
  output logic               diow_pin,
  input  logic [DATA_W-1:0]  bus_in,
  output logic [DATA_W-1:0]  bus_out,
  output logic               bus_oe,
  input  logic [DATA_W-1:0]  wr_word,
  output logic               wr_pop,
  output logic [DATA_W-1:0]  rd_word,
  output logic               rd_valid,
  output logic               busy
);

  localparam logic [1:0] TOP_MODE = 2'(NUM_MODES - 1);

  mdma_state_e        state_q, state_d;
  logic [1:0]         mode_q;
  logic               write_q;
  logic [COUNT_W-1:0] remain_q;
  logic [DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]  rd_word_q;
  logic               rd_valid_q;

  // Named internal events, also observed by the checker
  logic               dreq_act;
  logic               dack_act;
  logic               rd_strobe_act;
  logic               wr_strobe_act;
  logic               phase_done;
  logic               enter_act;
  logic               enter_rec;
  logic               last_word;
  logic               accept_start;
  logic               capture_rd;

  logic [TIMER_W-1:0] act_len, rec_len;

  mdma_timing_table #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .TIMER_W      (TIMER_W)
  ) u_table (
    .mode   (mode_q),
    .act_len(act_len),
    .rec_len(rec_len)
  );

  mdma_phase_counter #(
    .TIMER_W(TIMER_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (enter_act | enter_rec),
    .load_val(enter_act ? act_len : rec_len),
    .done    (phase_done)
  );

  mdma_pin_polarity #(.N(1)) u_pol_in (
    .level_in   (dreq_pin),
    .active_high(pol_dreq_high),
    .level_out  (dreq_act)
  );

  mdma_pin_polarity #(.N(3)) u_pol_out (
    .level_in   ({wr_strobe_act, rd_strobe_act, dack_act}),
    .active_high({pol_strobe_high, pol_strobe_high, pol_dack_high}),
    .level_out  ({diow_pin, dior_pin, dack_pin})
  );

  assign accept_start = (state_q == ST_IDLE) && start && (word_count != '0);
  assign last_word    = (remain_q == COUNT_W'(1));
  assign enter_rec    = (state_q == ST_ACT) && phase_done;
  assign enter_act    = (state_q == ST_SETUP) ||
                        ((state_q == ST_REC) && phase_done && !last_word && dreq_act);
  assign capture_rd   = enter_rec && !write_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept_start) state_d = ST_ARM;
      ST_ARM:   if (dreq_act)     state_d = ST_SETUP;
      ST_SETUP:                   state_d = ST_ACT;
      ST_ACT:   if (phase_done)   state_d = ST_REC;
      ST_REC: begin
        if (phase_done) begin
          if (last_word)     state_d = ST_IDLE;
          else if (dreq_act) state_d = ST_ACT;
          else               state_d = ST_ARM;
        end
      end
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= '0;
      write_q    <= 1'b0;
      remain_q   <= '0;
      data_q     <= '0;
      rd_word_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_valid_q <= capture_rd;
      if (accept_start) begin
        mode_q   <= (mode_sel > TOP_MODE) ? TOP_MODE : mode_sel;
        write_q  <= dir_write;
        remain_q <= word_count;
      end
      if ((state_q == ST_REC) && phase_done) remain_q <= remain_q - COUNT_W'(1);
      if (enter_act && write_q) data_q    <= wr_word;
      if (capture_rd)           rd_word_q <= bus_in;
    end
  end

  assign dack_act      = (state_q == ST_SETUP) || (state_q == ST_ACT) || (state_q == ST_REC);
  assign rd_strobe_act = (state_q == ST_ACT) && !write_q;
  assign wr_strobe_act = (state_q == ST_ACT) && write_q;

  assign wr_pop   = enter_act && write_q;
  assign bus_out  = data_q;
  assign bus_oe   = dack_act && write_q;
  assign rd_word  = rd_word_q;
  assign rd_valid = rd_valid_q;
  assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/mdma_strobe_gen_chk.sv
module mdma_strobe_gen_chk
  import mdma_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int DATA_W        = 16,
  parameter int TIMER_W       = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dreq_act,
  input logic              dack_act,
  input logic              rd_strobe_act,
  input logic              wr_strobe_act,
  input logic              rd_valid,
  input logic [DATA_W-1:0] bus_out,
  input logic [1:0]        mode_q
);

  logic               strobe_any;
  logic [TIMER_W-1:0] act_run;

  assign strobe_any = rd_strobe_act | wr_strobe_act;

  // Independent width counter: length of the current or just-ended strobe run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_run <= '0;
    else if (strobe_any) act_run <= act_run + TIMER_W'(1);
    else                 act_run <= '0;
  end

  p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_any) |-> (act_run == TIMER_W'(act_cycles(int'(mode_q), CLK_PERIOD_NS))));

  p_strobe_in_dack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_any |-> dack_act);

  p_dack_needs_dreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack_act) |-> $past(dreq_act));

  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_rd_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_strobe_act) && !rd_strobe_act));

  p_wdata_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe_act && $past(wr_strobe_act)) |-> $stable(bus_out));

  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe_act && wr_strobe_act));

endmodule

bind mdma_strobe_gen mdma_strobe_gen_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .DATA_W       (DATA_W),
  .TIMER_W      (TIMER_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dreq_act     (dreq_act),
  .dack_act     (dack_act),
  .rd_strobe_act(rd_strobe_act),
  .wr_strobe_act(wr_strobe_act),
  .rd_valid     (rd_valid),
  .bus_out      (bus_out),
  .mode_q       (mode_q)
);

// File: tb/mdma_strobe_gen_bench.sv
module mdma_strobe_gen_bench;

  localparam int P    = 4;
  localparam int DW   = 16;
  localparam int CW   = 16;
  localparam logic [15:0] JUNK = 16'hDEAD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = '0;
  logic          dir_write = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] word_count = '0;
  logic          pol_dreq_high = 1'b1;
  logic          pol_dack_high = 1'b0;
  logic          pol_strobe_high = 1'b0;
  logic          dreq_pin = 1'b0;
  logic          dack_pin, dior_pin, diow_pin;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic          bus_oe;
  logic [DW-1:0] wr_word = '0;
  logic          wr_pop;
  logic [DW-1:0] rd_word;
  logic          rd_valid;
  logic          busy;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  mdma_strobe_gen #(.CLK_PERIOD_NS(P), .DATA_W(DW), .COUNT_W(CW), .TIMER_W(8)) u_mdma_strobe_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dir_write(dir_write), .start(start),
    .word_count(word_count), .pol_dreq_high(pol_dreq_high), .pol_dack_high(pol_dack_high),
    .pol_strobe_high(pol_strobe_high), .dreq_pin(dreq_pin), .dack_pin(dack_pin),
    .dior_pin(dior_pin), .diow_pin(diow_pin), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .wr_word(wr_word), .wr_pop(wr_pop), .rd_word(rd_word),
    .rd_valid(rd_valid), .busy(busy)
  );

  // Bench-side timing model, written from the requirement formulas
  function automatic int up(input int ns);
    return (ns + P - 1) / P;
  endfunction

  function automatic int lim(input int m, input int k);
    int t0 [7] = '{480, 215, 215, 150, 100, 20, 20};
    int t1 [7] = '{150, 80, 50, 60, 30, 15, 5};
    int t2 [7] = '{120, 70, 25, 50, 20, 10, 5};
    return (m == 0) ? t0[k] : (m == 1) ? t1[k] : t2[k];
  endfunction

  function automatic int exp_act(input int m);
    int a;
    a = up(lim(m, 1));
    if (up(lim(m, 3)) + 1 > a) a = up(lim(m, 3)) + 1;
    if (up(lim(m, 4)) > a) a = up(lim(m, 4));
    return a;
  endfunction

  function automatic int exp_rec(input int m);
    int r;
    r = up(lim(m, 0)) - exp_act(m);
    for (int k = 2; k < 7; k++) begin
      if (k != 3 && k != 4 && up(lim(m, k)) > r) r = up(lim(m, k));
    end
    return r;
  endfunction

  function automatic logic [15:0] pat(input int k, input int m);
    return 16'((k + 1) * 16'h0137) ^ 16'((m + 1) << 12) ^ 16'h5A00;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s : actual %0d expected %0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog : actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_burst(input int m, input bit wr, input int n,
                           input bit pd, input bit pk, input bit ps, input bit drop);
    int ea, er, td, me, act_len, rec_len, words, pops, rvs, drop_left, guard;
    int bad_other, bad_oe, bad_wdata, bad_rdv;
    bit prev_st, prev_dk, prev_pop, pop_flag, gap_seen, dropped, st, dk, other;
    me = (m == 3) ? 2 : m;
    ea = exp_act(me);
    er = exp_rec(me);
    td = up(lim(me, 3));
    pol_dreq_high = pd; pol_dack_high = pk; pol_strobe_high = ps;
    dreq_pin = pd; mode_sel = 2'(m); dir_write = wr; word_count = CW'(n);
    wr_word = pat(0, me); bus_in = JUNK;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    act_len = 0; rec_len = 0; words = 0; pops = 0; rvs = 0; drop_left = 0;
    bad_other = 0; bad_oe = 0; bad_wdata = 0; bad_rdv = 0;
    prev_st = 0; prev_dk = 0; prev_pop = 0; pop_flag = 0; gap_seen = 0; dropped = 0;
    guard = 0;
    while (guard < 3000) begin
      @(negedge clk);
      guard++;
      dk    = (dack_pin == pk);
      st    = wr ? (diow_pin == ps) : (dior_pin == ps);
      other = wr ? (dior_pin == ps) : (diow_pin == ps);
      if (other) bad_other++;
      if (bus_oe !== (dk && wr)) bad_oe++;
      if (rd_valid) begin rvs++; if (wr) bad_rdv++; end
      if (st) begin
        act_len++;
        if (!prev_st) begin
          check(prev_dk, "R4 acknowledge ahead of strobe", prev_dk, 1);
          if (words == 0)   check(rec_len == 1, "R4 setup cycle", rec_len, 1);
          else if (dropped) check(rec_len == er + 1, "R5 resume after request gap", rec_len, er + 1);
          else              check(rec_len == er, "R3 recovery length", rec_len, er);
          if (wr) check(prev_pop, "R7 pop before write strobe", prev_pop, 1);
          rec_len = 0; dropped = 0;
        end
        if (wr && bus_out !== pat(words, me)) bad_wdata++;
      end else begin
        if (prev_st) begin
          check(act_len == ea, "R2 active width", act_len, ea);
          if (!wr) check(rd_valid && rd_word == pat(words, me), "R6 read capture",
                         int'(rd_word), int'(pat(words, me)));
          else     check(bus_out == pat(words, me), "R7 write hold",
                         int'(bus_out), int'(pat(words, me)));
          words++;
          act_len = 0;
          if (drop && words == 1) begin drop_left = 60; dropped = 1; end
        end
        if (dk) rec_len++;
      end
      if (prev_dk && !dk && busy && words > 0 && words < n) gap_seen = 1;
      if (prev_dk && !dk && words == n) check(rec_len == er, "R4 acknowledge hold", rec_len, er);
      // drive inputs for the next edge
      bus_in = (st && act_len > td) ? pat(words, me) : (JUNK ^ 16'(act_len));
      if (pop_flag) begin pops++; pop_flag = 0; end
      wr_word = pat(pops, me);
      if (wr_pop) pop_flag = 1;
      if (drop_left > 0) begin drop_left--; dreq_pin = ~pd; end
      else dreq_pin = pd;
      prev_st = st; prev_dk = dk; prev_pop = wr_pop;
      if (!busy && words > 0 && !dk) break;
    end
    check(words == n, "R5 all words moved", words, n);
    check(rvs == (wr ? 0 : n), "R6 read pulse count", rvs, wr ? 0 : n);
    check(bad_rdv == 0, "R6 no read pulse on write", bad_rdv, 0);
    check(pops == (wr ? n : 0), "R7 pop count", pops, wr ? n : 0);
    check(bad_oe == 0, "R7 output enable tracks acknowledge", bad_oe, 0);
    check(bad_wdata == 0, "R7 write data during strobe", bad_wdata, 0);
    check(bad_other == 0, "R8 unused strobe idle", bad_other, 0);
    if (drop) check(gap_seen, "R5 acknowledge released on request drop", gap_seen, 1);
    check(dack_pin == ~pk && dior_pin == ~ps && diow_pin == ~ps, "R8 idle pin levels",
          int'({dack_pin, dior_pin, diow_pin}), int'({~pk, ~ps, ~ps}));
    dreq_pin = ~pd;
  endtask

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    check(busy == 0 && bus_oe == 0 && rd_valid == 0, "R1 reset outputs",
          int'({busy, bus_oe, rd_valid}), 0);
    check(dack_pin == 1 && dior_pin == 1 && diow_pin == 1, "R1 reset pins inactive",
          int'({dack_pin, dior_pin, diow_pin}), 7);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: zero word count ignored
    word_count = '0; dreq_pin = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    bad = 0;
    repeat (20) begin @(negedge clk); if (busy || dack_pin != 1'b1) bad++; end
    check(bad == 0, "R10 zero count ignored", bad, 0);

    // Sweep: modes (3 checks R9 alias), directions, polarities, lengths
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 4; p++)
          for (int len = 1; len <= 3; len += 2)
            run_burst(m, w[0], len, ~p[0], p[0], p[1], 1'b0);

    // R5: request dropouts in both directions
    run_burst(2, 1'b1, 3, 1'b1, 1'b0, 1'b0, 1'b1);
    run_burst(1, 1'b0, 3, 1'b0, 1'b1, 1'b1, 1'b1);
    run_burst(0, 1'b1, 2, 1'b1, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule